// File: doc/BRIEF.md
# Single-Level Slot-1 Bus Arbiter

This block is the system-controller arbiter for a backplane bus. It serves one bus request level only, the highest-numbered one, and answers a request on that level by pulling the matching grant daisy-chain line low. Every other grant line is held high, which is the inactive state. Requests on the other levels get no answer.

Two conditions must both hold before the arbiter hands out a grant. The first is a software enable bit. The second is the slot-1 detect input. Detecting slot 1 does not turn the arbiter on by itself.

The request input and the bus-busy input each pass through a two-flop synchronizer. The grant lines leave the block straight from flops. A grant is issued when the bus is free. It stays up until the new master asserts bus-busy, and no second grant follows until bus-busy is released. If the requester withdraws before taking the bus, the grant is dropped and the arbiter goes back to idle.

Top module: `bus_arb_single`

## Requirements
- R1: While reset is asserted and on the first clock after it, all four grant outputs (`grant_n[3:0]`) read 4'b1111.
- R2: With `arb_en` low, no grant line goes low, even with `slot1_det` high, request level 3 asserted and the bus free.
- R3: With `slot1_det` low, no grant line goes low, even with `arb_en` high, request level 3 asserted and the bus free.
- R4: Requests on levels 0, 1 and 2 (`req_n[2:0]` low) never cause any grant line to go low.
- R5: When the arbiter is enabled, slot 1 is detected, `req_n[3]` is low and `busy_n` is high, `grant_n[3]` goes low on the third rising clock edge after the inputs change.
- R6: `grant_n[0]`, `grant_n[1]` and `grant_n[2]` are high in every cycle, and at most one grant line is low at any time.
- R7: No grant is issued while `busy_n` is low.
- R8: Once `busy_n` goes low during a grant, `grant_n[3]` goes high within three clocks. It stays high while `busy_n` is low, even if the request is still held. A new grant can follow only after `busy_n` returns high.
- R9: If `req_n[3]` goes high while the grant is out and before `busy_n` falls, `grant_n[3]` goes high. A later request is then granted again from idle.
- R10: Clearing `arb_en` or `slot1_det` while a grant is out raises `grant_n[3]` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en | input | 1 | Software arbiter enable bit |
| slot1_det | input | 1 | High when the board sits in slot 1 |
| req_n | input | 4 | Bus request lines, active low; only bit 3 is served |
| busy_n | input | 1 | Bus-busy line, active low |
| grant_n | output | 4 | Grant lines, active low, registered |

## Verification
The hardest state to reach from the ports is the wait-for-release state. The arbiter gets there when a master takes the bus while its own request is still held. From that state the grant must stay away even though the request and enable conditions all look satisfied. The stimulus first obtains a grant and then pulls `busy_n` low while keeping `req_n[3]` low. It checks that the grant line stays high for many cycles. It then releases `busy_n` and expects a fresh grant after the synchronizer and state latency.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_GRANT = 2'd1,
      ARB_HELD  = 2'd2
   } arb_state_e;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
   import arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       allow,
   input  logic       req,
   input  logic       busy,
   output logic       grant_on,
   output arb_state_e state
);
   arb_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ARB_IDLE:  if (allow && req && !busy) nxt = ARB_GRANT;
         ARB_GRANT: begin
            if (!allow)     nxt = ARB_IDLE;
            else if (busy)  nxt = ARB_HELD;
            else if (!req)  nxt = ARB_IDLE;
         end
         ARB_HELD:  if (!busy) nxt = ARB_IDLE;
         default:   nxt = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ARB_IDLE;
      else        state <= nxt;
   end

   assign grant_on = (nxt == ARB_GRANT);
endmodule

// File: rtl/arb_grant_drv.sv
module arb_grant_drv #(
   parameter int NUM_LEVELS   = 4,
   parameter int SERVED_LEVEL = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  grant_on,
   output logic [NUM_LEVELS-1:0] grant_n
);
   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_line
      if (i == SERVED_LEVEL) begin : g_served
         logic line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= 1'b1;
            else        line_q <= ~grant_on;
         end
         assign grant_n[i] = line_q;
      end else begin : g_parked
         assign grant_n[i] = 1'b1;
      end
   end
endmodule

// File: rtl/bus_arb_single.sv
module bus_arb_single
   import arb_pkg::*;
#(
   parameter int NUM_LEVELS   = 4,
   parameter int SERVED_LEVEL = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  arb_en,
   input  logic                  slot1_det,
   input  logic [NUM_LEVELS-1:0] req_n,
   input  logic                  busy_n,
   output logic [NUM_LEVELS-1:0] grant_n
);
   if (SERVED_LEVEL >= NUM_LEVELS || SERVED_LEVEL < 0) begin : g_bad_level
      $error("SERVED_LEVEL outside grant range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES below two");
   end

   logic [1:0] raw_in, sync_out;
   logic       req_seen, busy_seen, grant_on;
   arb_state_e state;

   assign raw_in = {req_n[SERVED_LEVEL], busy_n};

   arb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out));

   assign req_seen  = ~sync_out[1];
   assign busy_seen = ~sync_out[0];

   arb_ctrl ctrl_i (
      .clk(clk), .rst_n(rst_n), .allow(arb_en & slot1_det),
      .req(req_seen), .busy(busy_seen), .grant_on(grant_on), .state(state));

   arb_grant_drv #(.NUM_LEVELS(NUM_LEVELS), .SERVED_LEVEL(SERVED_LEVEL)) drv_i (
      .clk(clk), .rst_n(rst_n), .grant_on(grant_on), .grant_n(grant_n));
endmodule

// File: rtl/arb_chk.sv
module arb_chk
   import arb_pkg::*;
#(
   parameter int NUM_LEVELS   = 4,
   parameter int SERVED_LEVEL = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  arb_en,
   input logic                  slot1_det,
   input logic                  req_seen,
   input logic                  busy_seen,
   input arb_state_e            state,
   input logic [NUM_LEVELS-1:0] grant_n
);
   // R6
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~grant_n) <= 1);

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_park
      if (i != SERVED_LEVEL) begin : g_chk
         // R6
         parked_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant_n[i]);
      end
   end

   // R2
   no_grant_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_en |=> grant_n[SERVED_LEVEL]);

   // R3
   no_grant_noslot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot1_det |=> grant_n[SERVED_LEVEL]);

   // R5
   grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grant_n[SERVED_LEVEL]) |-> $past(req_seen && !busy_seen));

   // R8
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_n[SERVED_LEVEL] && busy_seen) |=> grant_n[SERVED_LEVEL]);

   // R8
   held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ARB_HELD && busy_seen) |=> grant_n[SERVED_LEVEL]);

   // R9
   req_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_n[SERVED_LEVEL] && !req_seen) |=> grant_n[SERVED_LEVEL]);
endmodule

bind bus_arb_single arb_chk #(.NUM_LEVELS(NUM_LEVELS), .SERVED_LEVEL(SERVED_LEVEL)) chk_i (
   .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .slot1_det(slot1_det),
   .req_seen(req_seen), .busy_seen(busy_seen), .state(state), .grant_n(grant_n));

// File: tb/bus_arb_single_test.sv
module bus_arb_single_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arb_en = 1'b0;
   logic       slot1_det = 1'b0;
   logic [3:0] req_n = 4'b1111;
   logic       busy_n = 1'b1;
   logic [3:0] grant_n;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   bus_arb_single uut (.clk(clk), .rst_n(rst_n), .arb_en(arb_en), .slot1_det(slot1_det),
      .req_n(req_n), .busy_n(busy_n), .grant_n(grant_n));

   task automatic chk(string tag, logic [3:0] exp);
      total++;
      if (grant_n !== exp) begin
         bad++;
         $display("FAIL %s grant_n actual=%b expected=%b", tag, grant_n, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_inputs();
      req_n = 4'b1111; busy_n = 1'b1; arb_en = 1'b1; slot1_det = 1'b1;
      cyc(6);
   endtask

   task automatic t_reset();
      cyc(1); chk("R1 in reset", 4'b1111);
      rst_n = 1'b1; cyc(1); chk("R1 after reset", 4'b1111);
   endtask

   task automatic t_disabled();
      arb_en = 1'b0; slot1_det = 1'b1; req_n = 4'b0111; busy_n = 1'b1;
      cyc(8); chk("R2 enable clear", 4'b1111);
      arb_en = 1'b1; slot1_det = 1'b0;
      cyc(8); chk("R3 no slot1", 4'b1111);
      idle_inputs();
   endtask

   task automatic t_other_levels();
      req_n = 4'b1000; cyc(8); chk("R4 levels 0-2 ignored", 4'b1111);
      req_n = 4'b1110; cyc(4); chk("R4 level 0 ignored", 4'b1111);
      idle_inputs();
   endtask

   task automatic t_basic_grant();
      req_n = 4'b0111;
      cyc(2); chk("R5 not before latency", 4'b1111);
      cyc(1); chk("R5 grant on level 3", 4'b0111);
      cyc(5); chk("R6 grant held, others high", 4'b0111);
      req_n = 4'b1111; cyc(4); chk("R9 withdrawn", 4'b1111);
      req_n = 4'b0111; cyc(4); chk("R9 regranted from idle", 4'b0111);
      idle_inputs();
   endtask

   task automatic t_busy();
      busy_n = 1'b0; req_n = 4'b0111;
      cyc(10); chk("R7 no grant while busy", 4'b1111);
      busy_n = 1'b1; cyc(4); chk("R7 grant after busy free", 4'b0111);
      busy_n = 1'b0; cyc(4); chk("R8 grant removed on busy", 4'b1111);
      cyc(20); chk("R8 held while busy, req still low", 4'b1111);
      busy_n = 1'b1; cyc(6); chk("R8 new grant after release", 4'b0111);
      idle_inputs();
   endtask

   task automatic t_drop_enable();
      req_n = 4'b0111; cyc(4); chk("R10 grant before disable", 4'b0111);
      arb_en = 1'b0; cyc(1); chk("R10 enable cleared", 4'b1111);
      arb_en = 1'b1; cyc(3); chk("R10 regrant", 4'b0111);
      slot1_det = 1'b0; cyc(1); chk("R10 slot cleared", 4'b1111);
      idle_inputs();
   endtask

   initial begin
      t_reset();
      idle_inputs();
      t_disabled();
      t_other_levels();
      t_basic_grant();
      t_busy();
      t_drop_enable();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule